// File: doc/BRIEF.md
# Firmware Glue Register File

This block is a small register file that firmware reaches over a byte-addressed register bus to get at platform services the operating system never touches. Through it, software can stop the system and hand back an exit code, learn which processor it is running on, read how many processors are present, exchange single characters with a console, and set the level of one per-processor interrupt line at a time.

Each bus access carries an address, a write flag, a byte count and the index of the requesting processor. Reads are answered one cycle after they are issued. All registers are 8 bits wide and are returned in the low byte of the read data. The console receive side shows a character that is waiting. That character is copied into the block only when firmware reads the input status. The console transmit side gives a one-cycle strobe for each byte written.

Top module: `fwglue_regs`

## Requirements
- R1: After reset the output status reads 1, the input status reads 0, both console data buffers read 0, every interrupt line is low, halt is low and the exit code is 0.
- R2: Only the low 6 address bits select a register, so an address and the same address plus any multiple of 0x40 reach the same register.
- R3: A write to offset 0x00 raises halt and latches bits 7:0 of the write data as the exit code. Halt then stays high, and later writes change neither halt nor the code.
- R4: A read of offset 0x04 returns the index of the requesting processor.
- R5: A read of offset 0x0a returns the parameter CPU_COUNT, or 1 when CPU_COUNT is 0.
- R6: A write to offset 0x08 uses data bits 7:0 as the line number and data bits 15:8 as the level. The line goes high for a nonzero level and low for zero. A 1-byte write drives a level of 0. A line holds its value until that line is written again.
- R7: An interrupt write whose line number is at or above NUM_LINES changes no line.
- R8: A read of offset 0x14 samples the console receive side. With rx_valid high, the input buffer takes rx_data, the status becomes 1 and the read returns 1. With rx_valid low, the buffer and the status both become 0 and the read returns 0. Offset 0x10 returns the input buffer.
- R9: A write to offset 0x18 pulses tx_valid for exactly one cycle with the byte on tx_data, keeps the byte for readback at 0x18, and sets the output status at 0x1a to 1.
- R10: Bus writes to 0x10, 0x14 and 0x1a store the written byte directly into the input buffer, the input status and the output status.
- R11: rsp_valid is high exactly in the cycle after each read. Read data bits above bit 7 are always zero, and reads of unmapped or write-only offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Byte count of the access |
| req_wdata | input | DATA_W | Write data, byte 0 in bits 7:0 |
| req_cpu | input | CPU_ID_W | Index of the requesting processor |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rx_valid | input | 1 | Console character available |
| rx_data | input | 8 | Console character |
| tx_valid | output | 1 | Console output strobe |
| tx_data | output | 8 | Console output byte |
| halt | output | 1 | System halt request |
| exit_code | output | 8 | Exit status |
| irq_lines | output | NUM_LINES | Per-processor interrupt levels |

## Verification
The bench sends interrupt writes with random line numbers, levels and byte counts, and compares the line vector with a bench model after every write. A design that ignored the byte count would raise a line on a 1-byte write. A design that did not range-check the line number would disturb some line when the number is out of range. The input status read is tested both with and without a character waiting, followed by a read of the data buffer. A design that returned the stale status, or that kept the old character when none was present, fails this test. The bench also checks that the exit code stays fixed after a second exit write, and it checks address aliasing, so a decoder that used more than 6 bits or that did not latch the first exit code is caught.

// File: rtl/fwglue_pkg.sv
package fwglue_pkg;
   localparam int OFS_W = 6;
   localparam logic [OFS_W-1:0] OFS_EXIT      = 6'h00;
   localparam logic [OFS_W-1:0] OFS_CPU_ID    = 6'h04;
   localparam logic [OFS_W-1:0] OFS_IRQ       = 6'h08;
   localparam logic [OFS_W-1:0] OFS_CPU_COUNT = 6'h0a;
   localparam logic [OFS_W-1:0] OFS_CIN_DATA  = 6'h10;
   localparam logic [OFS_W-1:0] OFS_CIN_STAT  = 6'h14;
   localparam logic [OFS_W-1:0] OFS_COUT_DATA = 6'h18;
   localparam logic [OFS_W-1:0] OFS_COUT_STAT = 6'h1a;
endpackage

// File: rtl/fwglue_ctrl.sv
module fwglue_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       exit_wr,
   input  logic [7:0] exit_byte,
   output logic       halt,
   output logic [7:0] exit_code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt      <= 1'b0;
         exit_code <= 8'h00;
      end else if (exit_wr && !halt) begin
         halt      <= 1'b1;
         exit_code <= exit_byte;
      end
   end

   // R3
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (halt && $stable(exit_code)));
   // R3
   halt_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exit_wr |=> halt);
endmodule

// File: rtl/fwglue_irq.sv
module fwglue_irq #(
   parameter int NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [7:0]           port,
   input  logic [7:0]           level,
   output logic [NUM_LINES-1:0] lines
);
   localparam logic [8:0] LIMIT = 9'(NUM_LINES);

   generate
      if (NUM_LINES < 1 || NUM_LINES > 256) begin : g_bad_lines
         $error("fwglue_irq: NUM_LINES must be 1..256");
      end
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         always_ff @(posedge clk) begin
            if (!rst_n)
               lines[i] <= 1'b0;
            else if (wr && port == 8'(i))
               lines[i] <= (level != 8'h00);
         end
      end
   endgenerate

   // R7
   out_of_range_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && {1'b0, port} >= LIMIT) |=> $stable(lines));
   // R6
   untouched_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(lines));
endmodule

// File: rtl/fwglue_console.sv
module fwglue_console (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_data_wr,
   input  logic       in_stat_wr,
   input  logic       out_data_wr,
   input  logic       out_stat_wr,
   input  logic       in_sample,
   input  logic [7:0] wbyte,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic [7:0] in_buf,
   output logic [7:0] in_stat,
   output logic [7:0] out_buf,
   output logic [7:0] out_stat,
   output logic       tx_valid,
   output logic [7:0] tx_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_buf   <= 8'h00;
         in_stat  <= 8'h00;
         out_buf  <= 8'h00;
         out_stat <= 8'h01;
         tx_valid <= 1'b0;
      end else begin
         tx_valid <= out_data_wr;
         if (in_sample) begin
            in_buf  <= rx_valid ? rx_data : 8'h00;
            in_stat <= rx_valid ? 8'h01 : 8'h00;
         end
         if (in_data_wr)  in_buf   <= wbyte;
         if (in_stat_wr)  in_stat  <= wbyte;
         if (out_stat_wr) out_stat <= wbyte;
         if (out_data_wr) begin
            out_buf  <= wbyte;
            out_stat <= 8'h01;
         end
      end
   end

   assign tx_data = out_buf;

   // R9
   tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_data_wr |=> (tx_valid && out_stat == 8'h01));
   // R9
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_data_wr |=> !tx_valid);
   // R8
   sample_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sample && rx_valid) |=> (in_stat == 8'h01 && in_buf == $past(rx_data)));
   // R8
   sample_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sample && !rx_valid) |=> (in_stat == 8'h00 && in_buf == 8'h00));
endmodule

// File: rtl/fwglue_regs.sv
module fwglue_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CPU_ID_W  = 4,
   parameter int NUM_LINES = 4,
   parameter int CPU_COUNT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [2:0]           req_size,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [CPU_ID_W-1:0]  req_cpu,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_rdata,
   input  logic                 rx_valid,
   input  logic [7:0]           rx_data,
   output logic                 tx_valid,
   output logic [7:0]           tx_data,
   output logic                 halt,
   output logic [7:0]           exit_code,
   output logic [NUM_LINES-1:0] irq_lines
);
   import fwglue_pkg::*;

   localparam int PAD_W = DATA_W - 8;

   generate
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("fwglue_regs: ADDR_W must cover the 6 decoded bits");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("fwglue_regs: DATA_W must carry port and level bytes");
      end
      if (CPU_ID_W < 1 || CPU_ID_W > 8) begin : g_bad_id
         $error("fwglue_regs: CPU_ID_W must be 1..8");
      end
   endgenerate

   logic [7:0] count_byte;
   generate
      if (CPU_COUNT == 0) begin : g_count_default
         assign count_byte = 8'd1;
      end else begin : g_count_cfg
         assign count_byte = 8'(CPU_COUNT);
      end
   endgenerate

   logic [OFS_W-1:0] ofs;
   logic             wr, rd;
   logic [7:0]       wbyte, level_byte;

   assign ofs        = req_addr[OFS_W-1:0];
   assign wr         = req_valid && req_write;
   assign rd         = req_valid && !req_write;
   assign wbyte      = req_wdata[7:0];
   assign level_byte = (req_size > 3'd1) ? req_wdata[15:8] : 8'h00;

   logic [7:0] in_buf, in_stat, out_buf, out_stat;

   fwglue_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .exit_wr   (wr && ofs == OFS_EXIT),
      .exit_byte (wbyte),
      .halt      (halt),
      .exit_code (exit_code)
   );

   fwglue_irq #(.NUM_LINES(NUM_LINES)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr && ofs == OFS_IRQ),
      .port  (wbyte),
      .level (level_byte),
      .lines (irq_lines)
   );

   fwglue_console u_con (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_data_wr  (wr && ofs == OFS_CIN_DATA),
      .in_stat_wr  (wr && ofs == OFS_CIN_STAT),
      .out_data_wr (wr && ofs == OFS_COUT_DATA),
      .out_stat_wr (wr && ofs == OFS_COUT_STAT),
      .in_sample   (rd && ofs == OFS_CIN_STAT),
      .wbyte       (wbyte),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .in_buf      (in_buf),
      .in_stat     (in_stat),
      .out_buf     (out_buf),
      .out_stat    (out_stat),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data)
   );

   logic [7:0] rd_byte;
   always_comb begin
      unique case (ofs)
         OFS_CPU_ID:    rd_byte = 8'(req_cpu);
         OFS_CPU_COUNT: rd_byte = count_byte;
         OFS_CIN_DATA:  rd_byte = in_buf;
         OFS_CIN_STAT:  rd_byte = rx_valid ? 8'h01 : 8'h00;
         OFS_COUT_DATA: rd_byte = out_buf;
         OFS_COUT_STAT: rd_byte = out_stat;
         default:       rd_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd;
         rsp_rdata <= rd ? {{PAD_W{1'b0}}, rd_byte} : '0;
      end
   end

   // R11
   rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid);
   // R11
   rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid);
   // R11
   rsp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[DATA_W-1:8] == '0));
endmodule

// File: tb/fwglue_regs_tb_top.sv
module fwglue_regs_tb_top;
   localparam int NL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_size = 3'd1;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_cpu = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rsp_valid, tx_valid, halt, rsp_valid2, tx_valid2, halt2;
   logic [31:0] rsp_rdata, rsp_rdata2;
   logic [7:0]  tx_data, exit_code, tx_data2, exit_code2;
   logic [NL-1:0] irq_lines, irq_lines2;

   int n_checks = 0;
   int n_err = 0;
   logic [NL-1:0] exp_lines = '0;
   logic [31:0] rd_val;

   always #2 clk = ~clk;

   fwglue_regs #(.NUM_LINES(NL), .CPU_COUNT(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
      .tx_data(tx_data), .halt(halt), .exit_code(exit_code),
      .irq_lines(irq_lines));

   fwglue_regs #(.NUM_LINES(NL), .CPU_COUNT(0)) dut_nocount (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_cpu(req_cpu), .rsp_valid(rsp_valid2), .rsp_rdata(rsp_rdata2),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid2),
      .tx_data(tx_data2), .halt(halt2), .exit_code(exit_code2),
      .irq_lines(irq_lines2));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic is_readable(input logic [5:0] o);
      return o == 6'h04 || o == 6'h0a || o == 6'h10 || o == 6'h14 ||
             o == 6'h18 || o == 6'h1a;
   endfunction

   function automatic logic [NL-1:0] irq_model(input logic [NL-1:0] cur,
         input logic [7:0] port, input logic [7:0] lvl, input logic [2:0] sz);
      logic [NL-1:0] n = cur;
      if (port < NL) n[port] = (sz > 1) && (lvl != 0);
      return n;
   endfunction

   // Drive at negedge; result sampled at the following negedge.
   task automatic access(input logic w, input logic [7:0] a, input logic [2:0] sz,
                         input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      rd_val = rsp_rdata;
      if (!w) check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
   endtask

   initial begin
      #(4 * 200000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c0d));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 halt", {31'b0, halt}, 0);
      check("R1 exit_code", {24'b0, exit_code}, 0);
      check("R1 irq", {28'b0, irq_lines}, 0);
      check("R11 idle rsp_valid", {31'b0, rsp_valid}, 0);
      access(0, 8'h1a, 1, 0); check("R1 out status", rd_val, 1);
      access(0, 8'h10, 1, 0); check("R1 in buffer", rd_val, 0);
      access(0, 8'h18, 1, 0); check("R1 out buffer", rd_val, 0);
      // R4 processor id
      req_cpu = 4'd3;
      access(0, 8'h04, 4, 0); check("R4 cpu id", rd_val, 3);
      req_cpu = 4'd9;
      // R2 alias
      access(0, 8'h44, 1, 0); check("R2 alias id", rd_val, 9);
      // R5 processor count
      access(0, 8'hca, 1, 0); check("R5 count cfg (via R2 alias)", rd_val, 4);
      check("R5 count default", rsp_rdata2, 1);
      // R9 console output
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 8'h18; req_size = 1; req_wdata = 32'hffff_ff41;
      @(negedge clk);
      req_valid = 0;
      check("R9 tx_valid", {31'b0, tx_valid}, 1);
      check("R9 tx_data", {24'b0, tx_data}, 32'h41);
      @(negedge clk);
      check("R9 tx single pulse", {31'b0, tx_valid}, 0);
      access(0, 8'h18, 1, 0); check("R9 out readback", rd_val, 32'h41);
      access(1, 8'h1a, 1, 0);
      access(0, 8'h1a, 1, 0); check("R10 out status write", rd_val, 0);
      access(1, 8'h18, 1, 32'h42);
      access(0, 8'h1a, 1, 0); check("R9 out status set", rd_val, 1);
      // R8 input sampling
      rx_valid = 1; rx_data = 8'h5a;
      access(0, 8'h14, 1, 0); check("R8 status hit", rd_val, 1);
      rx_valid = 0; rx_data = 8'h77;
      access(0, 8'h10, 1, 0); check("R8 buffer loaded", rd_val, 32'h5a);
      access(0, 8'h14, 1, 0); check("R8 status miss", rd_val, 0);
      access(0, 8'h10, 1, 0); check("R8 buffer cleared", rd_val, 0);
      // R10 direct overwrite
      access(1, 8'h10, 1, 32'h33);
      access(0, 8'h10, 1, 0); check("R10 in buffer write", rd_val, 32'h33);
      rx_valid = 1; rx_data = 8'h66;
      access(1, 8'h14, 1, 32'h07);
      rx_valid = 0;
      access(0, 8'h10, 1, 0); check("R10 status write no sample", rd_val, 32'h33);
      // R6 directed
      access(1, 8'h08, 2, 32'h0000_0102);
      exp_lines = irq_model(exp_lines, 8'h02, 8'h01, 2);
      check("R6 line 2 high", {28'b0, irq_lines}, {28'b0, exp_lines});
      access(1, 8'h08, 1, 32'h0000_ff02);
      exp_lines = irq_model(exp_lines, 8'h02, 8'hff, 1);
      check("R6 one-byte drives low", {28'b0, irq_lines}, {28'b0, exp_lines});
      access(1, 8'h08, 2, 32'h0000_0101);
      access(1, 8'h08, 2, 32'h0000_0104);
      exp_lines = irq_model(exp_lines, 8'h01, 8'h01, 2);
      check("R7 port 4 ignored", {28'b0, irq_lines}, {28'b0, exp_lines});
      // R6/R7 random
      for (int i = 0; i < 200; i++) begin
         logic [7:0] p, l;
         logic [2:0] sz;
         p  = 8'($urandom_range(0, 7));
         l  = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
         sz = 3'($urandom_range(1, 4));
         access(1, {2'($urandom_range(0, 3)), 6'h08}, sz, {16'h0, l, p});
         exp_lines = irq_model(exp_lines, p, l, sz);
         check("R6/R7 random irq", {28'b0, irq_lines}, {28'b0, exp_lines});
      end
      // R11 unmapped / write-only reads
      for (int i = 0; i < 100; i++) begin
         logic [5:0] o;
         o = 6'($urandom_range(0, 63));
         if (!is_readable(o)) begin
            access(0, {2'($urandom_range(0, 3)), o}, 3'($urandom_range(1, 4)), 0);
            check("R11 unmapped zero", rd_val, 0);
         end
      end
      // R3 exit
      access(1, 8'h00, 1, 32'h0000_12a5);
      check("R3 halt", {31'b0, halt}, 1);
      check("R3 exit code", {24'b0, exit_code}, 32'ha5);
      access(1, 8'h40, 1, 32'h0000_0003);
      check("R3 halt sticky", {31'b0, halt}, 1);
      check("R3 code kept", {24'b0, exit_code}, 32'ha5);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule